// File: doc/BRIEF.md
# Multi-Waveform Direct Digital Synthesis Core

This core turns a frequency tuning word into a periodic 8-bit sample stream for an external resistor-ladder DAC. A 32-bit phase register grows by the tuning word on every clock and wraps modulo 2^32. With a 200 MHz clock one tuning-word step is about 0.047 Hz, and the usable output runs from DC to half the clock rate. The top bits of the phase are shaped into one of six waveforms, picked by a 3-bit select: a sine read from a 256-entry internal table, a rising ramp, a falling ramp, a triangle, a square, or pseudo-random noise. A separate one-bit output carries the phase MSB as a fast square wave.

A run input gates the core. While run is low the phase is forced to zero and the sample output rests at mid-scale. When run rises the waveform starts from phase zero. All sample paths carry the same single register stage, so the sample is always aligned to one phase value. The fast output comes straight from the phase register.

Top module: `dds_wave_core`

## Requirements
- R1: On each rising clock edge with `run_i` high and reset inactive, the phase becomes phase + `ftw_i` modulo 2^32. Reset, or `run_i` low at the edge, makes the phase zero.
- R2: `hs_o` equals bit 31 of the current phase, with no extra register stage.
- R3: Select code 0 gives a sine taken from phase bits [31:24]. The entry for address a is within 1 of 128 + round(127·sin(2πa/256)). It is exactly 128, 255, 128 and 1 at addresses 0, 64, 128 and 192.
- R4: Code 1 gives phase bits [31:24] unchanged (rising ramp). Code 2 gives their bitwise inverse (falling ramp).
- R5: Code 3 gives a triangle. It is phase bits [30:23], inverted bit by bit when phase bit 31 is 1.
- R6: Code 4 gives 8'hFF when phase bit 31 is 1 and 8'h00 otherwise.
- R7: Code 5 gives noise: the low 8 bits of a 16-bit Fibonacci LFSR. The LFSR is seeded to 16'hACE1 in reset and steps on every clock out of reset, whatever `run_i` is. Its next state is {s[14:0], s[15]^s[13]^s[12]^s[10]}.
- R8: After an edge that samples `run_i` low, or during reset, `sample_o` is 8'h80 and `hs_o` is 0.
- R9: Codes 6 and 7 give mid-scale 8'h80.
- R10: Every waveform has one cycle of latency. The sample visible after edge n is built from the phase value and LFSR state held just before edge n, and from the select and run sampled at edge n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_i | input | 1 | High to generate, low to stop and clear the phase |
| ftw_i | input | 32 | Frequency tuning word added to the phase each clock |
| wave_i | input | 3 | Waveform select: 0 sine, 1 rising ramp, 2 falling ramp, 3 triangle, 4 square, 5 noise |
| sample_o | output | 8 | Sample word for the DAC |
| hs_o | output | 1 | Fast square output, the phase MSB |

## Verification
Two things can happen in the same edge: the phase is cleared or restarted by `run_i`, and the waveform select changes. The bench provokes this on purpose by raising `run_i` and changing `wave_i` at one clock edge, both in a directed step and through random segments that redraw both together. A cycle-exact reference model of phase, LFSR and shaping judges every following sample. That sample must show the new shape applied to phase zero, and the next one must show the shape applied to the first tuning-word step. Phase wraparound during a triangle fold and during a falling ramp is judged the same way.

// File: rtl/dds_pkg.sv
// Package: shared waveform codes and the noise generator's step function.
// Assumes a 3-bit select; codes above WAVE_NOISE are treated as unused.
package dds_pkg;

    typedef enum logic [2:0] {
        WAVE_SINE    = 3'd0,
        WAVE_RAMP_UP = 3'd1,
        WAVE_RAMP_DN = 3'd2,
        WAVE_TRI     = 3'd3,
        WAVE_SQUARE  = 3'd4,
        WAVE_NOISE   = 3'd5
    } wave_e;

    localparam int          NOISE_W    = 16;
    localparam logic [15:0] NOISE_SEED = 16'hACE1;

    // Maximal-length Fibonacci step, taps 16/14/13/11
    function automatic logic [NOISE_W-1:0] noise_step(input logic [NOISE_W-1:0] s);
        return {s[NOISE_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/dds_phase_acc.sv
// Phase register: adds the tuning word every clock while running, wraps
// modulo 2^PHASE_W, and clears to zero in reset or while stopped.
module dds_phase_acc #(
    parameter int PHASE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic [PHASE_W-1:0] ftw_i,
    output logic [PHASE_W-1:0] phase_o
);

    // Accumulate or clear the phase
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) phase_o <= '0;
        else                  phase_o <= phase_o + ftw_i;
    end

endmodule

// File: rtl/dds_sine_rom.sv
// Registered sine table with one cycle of latency. The contents are computed
// at elaboration with an integer rational approximation of the sine (error
// well under one LSB at 8 bits). Assumes ADDR_W small enough that
// 16*P*P fits comfortably in 64 bits.
module dds_sine_rom #(
    parameter int ADDR_W = 8,
    parameter int OUT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [OUT_W-1:0]  data_o
);

    localparam int    DEPTH = 1 << ADDR_W;
    localparam int    HALF  = DEPTH / 2;
    localparam longint MID  = longint'(1) << (OUT_W - 1);
    localparam longint AMP  = MID - 1;

    function automatic logic [DEPTH*OUT_W-1:0] build_table();
        logic [DEPTH*OUT_W-1:0] tbl;
        longint t, prod, num, den, mag;
        tbl = '0;
        for (int i = 0; i < DEPTH; i++) begin
            t    = longint'(i % HALF);
            prod = t * (longint'(HALF) - t);
            num  = 16 * prod;
            den  = 5 * longint'(HALF) * longint'(HALF) - 4 * prod;
            mag  = (AMP * num + den / 2) / den;
            if (i < HALF) tbl[i*OUT_W +: OUT_W] = OUT_W'(MID + mag);
            else          tbl[i*OUT_W +: OUT_W] = OUT_W'(MID - mag);
        end
        return tbl;
    endfunction

    localparam logic [DEPTH*OUT_W-1:0] TABLE = build_table();

    // Table read register
    always_ff @(posedge clk) begin
        if (!rst_n) data_o <= OUT_W'(MID);
        else        data_o <= TABLE[addr_i*OUT_W +: OUT_W];
    end

endmodule

// File: rtl/dds_noise.sv
// Free-running LFSR noise source: seeded in reset, steps on every clock.
module dds_noise (
    input  logic                        clk,
    input  logic                        rst_n,
    output logic [dds_pkg::NOISE_W-1:0] state_o
);

    // Seed or step the register
    always_ff @(posedge clk) begin
        if (!rst_n) state_o <= dds_pkg::NOISE_SEED;
        else        state_o <= dds_pkg::noise_step(state_o);
    end

endmodule

// File: rtl/dds_shaper.sv
// Registered shaping of every non-table waveform from the phase and noise
// state. Sine and unused codes produce mid-scale here; the top picks the
// table output for sine. Assumes PHASE_W > OUT_W and NOISE_W >= OUT_W.
module dds_shaper #(
    parameter int PHASE_W = 32,
    parameter int OUT_W   = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [PHASE_W-1:0]          phase_i,
    input  logic [2:0]                  wave_i,
    input  logic [dds_pkg::NOISE_W-1:0] noise_i,
    output logic [OUT_W-1:0]            shape_o
);
    import dds_pkg::*;

    localparam logic [OUT_W-1:0] MID = OUT_W'(1) << (OUT_W - 1);

    logic             msb;
    logic [OUT_W-1:0] top_bits;
    logic [OUT_W-1:0] fold_bits;
    logic [OUT_W-1:0] shape_d;

    assign msb       = phase_i[PHASE_W-1];
    assign top_bits  = phase_i[PHASE_W-1 -: OUT_W];
    assign fold_bits = phase_i[PHASE_W-2 -: OUT_W];

    // Select the shape for the current phase
    always_comb begin
        case (wave_e'(wave_i))
            WAVE_RAMP_UP: shape_d = top_bits;
            WAVE_RAMP_DN: shape_d = ~top_bits;
            WAVE_TRI:     shape_d = fold_bits ^ {OUT_W{msb}};
            WAVE_SQUARE:  shape_d = {OUT_W{msb}};
            WAVE_NOISE:   shape_d = noise_i[OUT_W-1:0];
            default:      shape_d = MID;
        endcase
    end

    // Output register matching the table's latency
    always_ff @(posedge clk) begin
        if (!rst_n) shape_o <= MID;
        else        shape_o <= shape_d;
    end

endmodule

// File: rtl/dds_wave_core.sv
// Top: phase register, sine table, noise source and shaper, followed by the
// final select. All sample paths carry one register stage. The fast output
// is the phase MSB taken straight from the phase register.
module dds_wave_core #(
    parameter int PHASE_W = 32,
    parameter int OUT_W   = 8,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic [PHASE_W-1:0] ftw_i,
    input  logic [2:0]         wave_i,
    output logic [OUT_W-1:0]   sample_o,
    output logic               hs_o
);
    import dds_pkg::*;

    localparam logic [OUT_W-1:0] MID = OUT_W'(1) << (OUT_W - 1);

    logic [PHASE_W-1:0] phase;
    logic [NOISE_W-1:0] noise;
    logic [OUT_W-1:0]   sine_q;
    logic [OUT_W-1:0]   shape_q;
    logic               run_q;
    logic               sine_sel_q;

    dds_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .ftw_i(ftw_i), .phase_o(phase)
    );

    dds_sine_rom #(.ADDR_W(ADDR_W), .OUT_W(OUT_W)) u_rom (
        .clk(clk), .rst_n(rst_n), .addr_i(phase[PHASE_W-1 -: ADDR_W]), .data_o(sine_q)
    );

    dds_noise u_noise (
        .clk(clk), .rst_n(rst_n), .state_o(noise)
    );

    dds_shaper #(.PHASE_W(PHASE_W), .OUT_W(OUT_W)) u_shape (
        .clk(clk), .rst_n(rst_n), .phase_i(phase), .wave_i(wave_i),
        .noise_i(noise), .shape_o(shape_q)
    );

    // Align run state and table choice with the registered samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q      <= 1'b0;
            sine_sel_q <= 1'b0;
        end else begin
            run_q      <= run_i;
            sine_sel_q <= (wave_e'(wave_i) == WAVE_SINE);
        end
    end

    assign sample_o = !run_q ? MID : (sine_sel_q ? sine_q : shape_q);
    assign hs_o     = phase[PHASE_W-1];

endmodule

// File: rtl/dds_wave_core_chk.sv
// Port-level checker for dds_wave_core, attached with bind below.
module dds_wave_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        run_i,
    input logic [31:0] ftw_i,
    input logic [2:0]  wave_i,
    input logic [7:0]  sample_o,
    input logic        hs_o
);

    AST_STOP_MIDSCALE: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> sample_o == 8'h80);                                   // R8

    AST_STOP_PHASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !hs_o);                                                // R8

    AST_ZERO_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && ftw_i == 32'd0) |=> $stable(hs_o));                     // R1

    AST_SQUARE_FOLLOWS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && wave_i == 3'd4) |=> sample_o == {8{$past(hs_o)}});      // R6

    AST_UNUSED_CODE_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && wave_i > 3'd5) |=> sample_o == 8'h80);                  // R9

    AST_NOISE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && wave_i == 3'd5 && $past(rst_n) && $past(run_i) && $past(wave_i) == 3'd5)
        |=> sample_o[7:1] == $past(sample_o[6:0]));                       // R7

endmodule

bind dds_wave_core dds_wave_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .ftw_i(ftw_i),
    .wave_i(wave_i), .sample_o(sample_o), .hs_o(hs_o)
);

// File: tb/sim_dds_wave_core.sv
module sim_dds_wave_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_i = 1'b0;
    logic [31:0] ftw_i = '0;
    logic [2:0]  wave_i = '0;
    logic [7:0]  sample_o;
    logic        hs_o;

    int tests = 0;
    int fails = 0;
    bit mon_en = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    dds_wave_core u0 (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .ftw_i(ftw_i),
        .wave_i(wave_i), .sample_o(sample_o), .hs_o(hs_o)
    );

    // Reference for R3: rounded ideal sine
    function automatic int sine_ref(input int a);
        real v;
        v = 127.0 * $sin(2.0 * 3.14159265358979 * a / 256.0);
        return 128 + $rtoi(v >= 0.0 ? v + 0.5 : v - 0.5);
    endfunction

    // Reference for R4 R5 R6 R7 R9
    function automatic logic [7:0] shape_ref(input logic [31:0] ph, input logic [2:0] w,
                                             input logic [15:0] lf);
        case (w)
            3'd1: return ph[31:24];
            3'd2: return ~ph[31:24];
            3'd3: return ph[31] ? ~ph[30:23] : ph[30:23];
            3'd4: return ph[31] ? 8'hFF : 8'h00;
            3'd5: return lf[7:0];
            default: return 8'h80;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] w);
        case (w)
            3'd0: return "R3 R10";
            3'd1, 3'd2: return "R4 R10";
            3'd3: return "R5 R10";
            3'd4: return "R6 R10";
            3'd5: return "R7 R10";
            default: return "R9";
        endcase
    endfunction

    // Cycle-exact reference model (R1, R7, R8, R10)
    logic [31:0] m_ph;
    logic [15:0] m_lf;
    logic [7:0]  m_exp;
    logic [7:0]  m_addr;
    logic        m_sine;
    logic        m_run;
    logic [2:0]  m_wave;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph <= '0; m_lf <= 16'hACE1; m_exp <= 8'h80;
            m_sine <= 1'b0; m_run <= 1'b0; m_wave <= 3'd0; m_addr <= '0;
        end else begin
            m_ph   <= run_i ? m_ph + ftw_i : 32'd0;
            m_lf   <= {m_lf[14:0], m_lf[15] ^ m_lf[13] ^ m_lf[12] ^ m_lf[10]};
            m_exp  <= run_i ? shape_ref(m_ph, wave_i, m_lf) : 8'h80;
            m_sine <= run_i && wave_i == 3'd0;
            m_run  <= run_i;
            m_wave <= wave_i;
            m_addr <= m_ph[31:24];
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare outputs every cycle, away from the rising edge
    always @(negedge clk) begin
        if (mon_en) begin
            check(hs_o == m_ph[31], "R1 R2 hs", hs_o, m_ph[31]);
            if (!m_run) begin
                check(sample_o == 8'h80, "R8 stopped", sample_o, 8'h80);
            end else if (m_sine) begin
                int e;
                int d;
                e = sine_ref(m_addr);
                d = int'(sample_o) - e;
                if (m_addr == 0 || m_addr == 64 || m_addr == 128 || m_addr == 192)
                    check(sample_o == 8'(e), "R3 quarter point", sample_o, e);
                else
                    check(d >= -1 && d <= 1, "R3 R10 sine", sample_o, e);
            end else begin
                check(sample_o == m_exp, tag_of(m_wave), sample_o, m_exp);
            end
        end
    end

    task automatic segment(input bit r, input logic [2:0] w, input logic [31:0] f, input int n);
        run_i = r; wave_i = w; ftw_i = f;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        repeat (4) @(negedge clk);
        // R8: reset state
        check(sample_o == 8'h80, "R8 reset sample", sample_o, 8'h80);
        check(hs_o == 1'b0, "R8 reset hs", hs_o, 0);
        rst_n = 1'b1;
        mon_en = 1'b1;

        segment(1, 3'd0, 32'h0100_0000, 260);  // R3 every table address
        segment(1, 3'd1, 32'h0123_4567, 100);  // R4 rising ramp
        segment(1, 3'd2, 32'hFFFF_FFFF, 100);  // R1 wrap, R4 falling ramp
        segment(1, 3'd3, 32'h0200_0000, 300);  // R5 both triangle halves
        segment(1, 3'd4, 32'h8000_0000, 20);   // R2 R6 toggle every cycle
        segment(1, 3'd5, 32'h0000_1000, 200);  // R7 noise
        segment(1, 3'd6, 32'h0300_0000, 20);   // R9
        segment(1, 3'd7, 32'h0300_0000, 20);   // R9
        segment(0, 3'd5, 32'h0300_0000, 10);   // R8 stop
        segment(1, 3'd3, 32'h1000_0000, 40);   // restart + select change same edge
        segment(1, 3'd1, 32'h0000_0000, 20);   // R1 zero step holds phase
        segment(0, 3'd0, 32'h0100_0000, 3);
        segment(1, 3'd0, 32'h0040_0000, 50);   // restart into sine

        for (int k = 0; k < 80; k++) begin
            logic [31:0] f;
            case ($urandom % 4)
                0: f = $urandom;
                1: f = $urandom % 65536;
                2: f = 32'd1 << ($urandom % 32);
                default: f = 32'hFFFF_FFFF - ($urandom % 4096);
            endcase
            segment(($urandom % 8) != 0, 3'($urandom % 8), f, 5 + ($urandom % 96));
        end

        mon_en = 1'b0;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule